// File: doc/BRIEF.md
# Minifloat to Single-Precision Widener

This unit takes one reduced-precision floating-point code and returns the IEEE single-precision word with exactly the same value. It accepts four source layouts, chosen per cycle by a two-bit select: E4M3 (bias 7), E5M2 (bias 15), E8M7 (bias 127) and E5M10 (bias 15). Each of these values fits exactly in single precision, so the unit never rounds. Its tasks are to detect special codes, move the exponent to the new bias, pad the fraction with zeros on the right, and turn source subnormals into single-precision normals where the exponent range allows it.

The conversion itself is combinational. The result goes through one output register that has an active-low asynchronous reset, so a code presented before a rising edge appears on the output after that edge. A vector datapath would place one unit per lane, in front of arithmetic that works in single precision.

Top module: `mf_widen`

## Requirements
- R1: While rst_ni is low, word_o is 0. Otherwise word_o holds the conversion of the fmt_i/code_i pair sampled at the previous rising clock edge.
- R2: The select values are 0 for E4M3, 1 for E5M2, 2 for E8M7 and 3 for E5M10. The 8-bit formats use code_i[7:0] with the sign in bit 7. The 16-bit formats use code_i[15:0] with the sign in bit 15. For the 8-bit formats, code_i[15:8] has no effect on the output.
- R3: Every NaN source code gives 0x7FC00000, whatever its sign and payload. For E4M3 the only NaN codes are exponent 0xF with mantissa 0x7. For the other formats, an all-ones exponent with a nonzero mantissa is NaN.
- R4: For E5M2, E8M7 and E5M10, an all-ones exponent with a zero mantissa gives 0x7F800000 with the source sign in bit 31.
- R5: An E4M3 code with exponent 0xF and mantissa 0 to 6 is a finite normal value. Its output exponent field is 135.
- R6: A source with zero exponent and zero mantissa gives zero exponent and zero mantissa fields, and keeps its sign bit.
- R7: For a normal source with exponent field e, the output exponent field is e + 127 - bias.
- R8: For a normal source, the output mantissa field is the source mantissa placed in its top bits, with zeros below.
- R9: A subnormal E4M3, E5M2 or E5M10 source becomes a single-precision normal. The leading one of its mantissa moves to the hidden position and is dropped. The exponent is reduced by one for each shift.
- R10: A subnormal E8M7 source gives a single-precision subnormal: exponent field 0 and mantissa field equal to the source mantissa shifted left by 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Source format select |
| code_i | input | 16 | Source code, right-aligned |
| word_o | output | 32 | Registered single-precision result |

## Verification
All four formats are swept over every code, and each result is compared with a value the bench builds by normalising an integer significand and power of two. The sweep covers every boundary case. One case is the E4M3 top binade: a design that treated it as infinity or NaN would saturate seven finite values. Another is subnormals with the leading one at every position: an off-by-one in the priority encoder or the shift would give exponents or fractions off by a factor of two. The E8M7 subnormals must stay subnormal, because renormalising them would produce garbage exponents. NaN codes with a set sign must lose the sign, signed zeros and infinities must keep it, and unused upper bits driven with garbage must have no effect on the 8-bit formats.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam int CODE_W   = 16;
  localparam int MANT_W   = 10;  // widest source mantissa
  localparam int EXP_W    = 8;
  localparam int OUT_W    = 32;
  localparam int OUT_MANT = 23;
  localparam int OUT_BIAS = 127;
  localparam int POS_W    = $clog2(MANT_W);
  localparam int PAD_W    = OUT_MANT - MANT_W;
  // exponent of a renormalised subnormal is pos + SUB_OFF - bias
  localparam int SUB_OFF  = OUT_BIAS - (MANT_W - 1);
  localparam logic [OUT_W-1:0] QNAN_WORD = 32'h7FC0_0000;

  typedef enum logic [1:0] {
    SRC_E4M3  = 2'd0,
    SRC_E5M2  = 2'd1,
    SRC_E8M7  = 2'd2,
    SRC_E5M10 = 2'd3
  } src_fmt_e;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant;   // left-aligned
    logic [EXP_W-1:0]  bias;
    logic              nan;
    logic              inf;
    logic              zero;
    logic              sub;
    logic              wide_exp; // exponent as wide as the output
  } src_fields_t;
endpackage

// File: rtl/mf_unpack.sv
module mf_unpack
  import mf_pkg::*;
(
  input  logic [1:0]        fmt_i,
  input  logic [CODE_W-1:0] code_i,
  output src_fields_t       f_o
);
  logic              all_ones;
  logic              mant_nz;
  logic              e4m3_nan;

  always_comb begin
    f_o = '0;
    all_ones = 1'b0;
    e4m3_nan = 1'b0;
    unique case (src_fmt_e'(fmt_i))
      SRC_E4M3: begin
        f_o.sign = code_i[7];
        f_o.exp  = {4'b0, code_i[6:3]};
        f_o.mant = {code_i[2:0], 7'b0};
        f_o.bias = 8'd7;
        e4m3_nan = (code_i[6:0] == 7'h7F);
      end
      SRC_E5M2: begin
        f_o.sign = code_i[7];
        f_o.exp  = {3'b0, code_i[6:2]};
        f_o.mant = {code_i[1:0], 8'b0};
        f_o.bias = 8'd15;
        all_ones = &code_i[6:2];
      end
      SRC_E8M7: begin
        f_o.sign = code_i[15];
        f_o.exp  = code_i[14:7];
        f_o.mant = {code_i[6:0], 3'b0};
        f_o.bias = 8'd127;
        all_ones = &code_i[14:7];
        f_o.wide_exp = 1'b1;
      end
      default: begin
        f_o.sign = code_i[15];
        f_o.exp  = {3'b0, code_i[14:10]};
        f_o.mant = code_i[9:0];
        f_o.bias = 8'd15;
        all_ones = &code_i[14:10];
      end
    endcase
    mant_nz  = |f_o.mant;
    f_o.nan  = e4m3_nan | (all_ones & mant_nz);
    f_o.inf  = all_ones & ~mant_nz;
    f_o.zero = (f_o.exp == '0) & ~mant_nz;
    f_o.sub  = (f_o.exp == '0) & mant_nz;
  end
endmodule

// File: rtl/mf_lead_one.sv
module mf_lead_one #(
  parameter int W   = 10,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o
);
  // highest set bit wins; zero vector gives 0 (unused by caller)
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = PW'(i);
    end
  end
endmodule

// File: rtl/mf_widen.sv
module mf_widen
  import mf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [OUT_W-1:0]  word_o
);
  src_fields_t             f;
  logic [POS_W-1:0]        lead_pos;
  logic [POS_W-1:0]        shamt;
  logic [OUT_MANT-1:0]     mant_ext;
  logic [OUT_MANT-1:0]     mant_shl;
  logic [EXP_W+1:0]        exp_norm;
  logic [EXP_W+1:0]        exp_sub;
  logic [OUT_W-1:0]        word_d;
  logic [OUT_W-1:0]        word_q;

  mf_unpack u_unpack (.fmt_i(fmt_i), .code_i(code_i), .f_o(f));

  mf_lead_one #(.W(MANT_W)) u_lead (.vec_i(f.mant), .pos_o(lead_pos));

  always_comb begin
    mant_ext = {f.mant, {PAD_W{1'b0}}};
    shamt    = POS_W'(MANT_W) - lead_pos;
    mant_shl = mant_ext << shamt;  // leading one falls off the top
    exp_norm = (EXP_W+2)'(f.exp) + (EXP_W+2)'(OUT_BIAS) - (EXP_W+2)'(f.bias);
    exp_sub  = (EXP_W+2)'(lead_pos) + (EXP_W+2)'(SUB_OFF) - (EXP_W+2)'(f.bias);
    if (f.nan)
      word_d = QNAN_WORD;
    else if (f.inf)
      word_d = {f.sign, {EXP_W{1'b1}}, {OUT_MANT{1'b0}}};
    else if (f.zero)
      word_d = {f.sign, {(OUT_W-1){1'b0}}};
    else if (f.sub && f.wide_exp)
      word_d = {f.sign, {EXP_W{1'b0}}, mant_ext};
    else if (f.sub)
      word_d = {f.sign, exp_sub[EXP_W-1:0], mant_shl};
    else
      word_d = {f.sign, exp_norm[EXP_W-1:0], mant_ext};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/mf_widen_chk.sv
module mf_widen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  fmt_i,
  input logic [15:0] code_i,
  input logic [31:0] word_o
);
  a_r3_e5m2_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd1 && code_i[6:2] == 5'h1F && code_i[1:0] != 2'b0)
    |=> word_o == 32'h7FC0_0000);

  a_r3_e4m3_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd0 && code_i[6:0] == 7'h7F) |=> word_o == 32'h7FC0_0000);

  a_r4_e5m10_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd3 && code_i[14:0] == 15'h7C00)
    |=> word_o[30:0] == 31'h7F80_0000 && word_o[31] == $past(code_i[15]));

  a_r5_e4m3_finite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd0 && code_i[6:3] == 4'hF && code_i[2:0] != 3'h7)
    |=> word_o[30:23] == 8'd135);

  a_r6_zero_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd2 && code_i[14:0] == 15'h0)
    |=> word_o[30:0] == 31'h0 && word_o[31] == $past(code_i[15]));

  a_r7_e5m2_rebias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd1 && code_i[6:2] != 5'h0 && code_i[6:2] != 5'h1F)
    |=> word_o[30:23] == 8'($past(code_i[6:2])) + 8'd112);

  a_r8_e5m10_mant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd3 && code_i[14:10] != 5'h0 && code_i[14:10] != 5'h1F)
    |=> word_o[22:13] == $past(code_i[9:0]) && word_o[12:0] == 13'h0);

  a_r10_e8m7_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'd2 && code_i[14:7] == 8'h0)
    |=> word_o[30:23] == 8'h0 && word_o[22:16] == $past(code_i[6:0]));
endmodule

bind mf_widen mf_widen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fmt_i(fmt_i), .code_i(code_i), .word_o(word_o)
);

// File: tb/mf_widen_bench.sv
`timescale 1ns/1ps
module mf_widen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fmt_i = 2'd3;
  logic [15:0] code_i = 16'h3C00;
  logic [31:0] word_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  mf_widen u_mf_widen (.clk_i(clk_i), .rst_ni(rst_ni), .fmt_i(fmt_i),
                       .code_i(code_i), .word_o(word_o));

  function automatic void geom(input logic [1:0] f, input logic [15:0] c,
                               output int s, output int e, output int m,
                               output int eb, output int mb, output int bias);
    case (f)
      2'd0: begin eb = 4; mb = 3;  bias = 7;   s = c[7]; end
      2'd1: begin eb = 5; mb = 2;  bias = 15;  s = c[7]; end
      2'd2: begin eb = 8; mb = 7;  bias = 127; s = c[15]; end
      default: begin eb = 5; mb = 10; bias = 15; s = c[15]; end
    endcase
    m = int'(c) & ((1 << mb) - 1);
    e = (int'(c) >> mb) & ((1 << eb) - 1);
  endfunction

  function automatic logic [31:0] ref_word(input logic [1:0] f, input logic [15:0] c);
    int s, e, m, eb, mb, bias, pw, biased;
    longint sig;
    logic [31:0] r;
    geom(f, c, s, e, m, eb, mb, bias);
    if (f == 2'd0) begin
      if (e == 15 && m == 7) return 32'h7FC0_0000;
    end else if (e == (1 << eb) - 1) begin
      if (m != 0) return 32'h7FC0_0000;
      return {s[0], 31'h7F80_0000};
    end
    if (e == 0 && m == 0) return {s[0], 31'h0};
    sig = (e == 0) ? longint'(m) : longint'(m + (1 << mb));
    pw  = ((e == 0) ? 1 : e) - bias - mb;
    while (sig < (64'sd1 << 23)) begin sig = sig << 1; pw = pw - 1; end
    biased = pw + 23 + 127;
    if (biased >= 1) r = {s[0], biased[7:0], sig[22:0]};
    else begin
      sig = sig >> (1 - biased);
      r = {s[0], 8'h0, sig[22:0]};
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] f, input logic [15:0] c);
    int s, e, m, eb, mb, bias;
    geom(f, c, s, e, m, eb, mb, bias);
    if (f == 2'd0 && e == 15) return (m == 7) ? "R3" : "R5";
    if (e == (1 << eb) - 1) return (m != 0) ? "R3" : "R4";
    if (e == 0 && m == 0) return "R6";
    if (e == 0) return (f == 2'd2) ? "R10" : "R9";
    return "R7,R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s fmt=%0d code=%h act=%h exp=%h", tag, fmt_i, code_i, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [15:0] c, input string tag);
    fmt_i = f;
    code_i = c;
    @(negedge clk_i);
    check(tag, word_o, ref_word(f, c));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", word_o, 32'h0);
    rst_ni = 1'b1;
    apply(2'd3, 16'h3C00, "R1");
    for (int f = 0; f < 4; f++) begin
      int n = (f == 0 || f == 1) ? 256 : 65536;
      for (int i = 0; i < n; i++) begin
        logic [15:0] c;
        c = 16'(i);
        if (n == 256) c[15:8] = 8'(i * 29 + 5);  // R2: junk in unused byte
        apply(2'(f), c, (n == 256) ? {"R2 ", tag_of(2'(f), c)} : tag_of(2'(f), c));
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule